// File: doc/BRIEF.md
# Port Statistics Snapshot Unit

This block keeps a set of live event counters for every port of a switch and hands them to a management processor through three 16-bit registers. Each port has a set of single-event counters, and one wide byte counter that accumulates a length value whenever a length strobe arrives. All live counters saturate at all-ones instead of wrapping.

Software reads statistics in two steps. First it writes a snapshot command naming a port. In one clock edge, the block freezes every counter of that port into a capture bank. Then, for each statistic, software writes a read command naming an entry index and polls the busy flag. It then fetches the selected 32-bit entry as a high and a low half. The wide byte counter spans two consecutive entries, and both halves come from the same frozen value. Every command finishes one cycle after it is accepted, so the busy flag is never seen set for more than one poll.

Top module: `stat_snap_unit`

## Requirements
- R1: After reset, all live counters, the capture bank, the readout value and the busy flag are zero, and the command, high and low registers read as zero.
- R2: A write to the command register (address 0x1D) whose bits 15:12 are 0xD (snapshot) or 0xC (read entry) is accepted and sets busy for exactly one cycle. Reading address 0x1D returns busy in bit 15 and bits 14:0 of the last accepted command.
- R3: A snapshot copies every live counter of the port in command bits 4:0 into the capture bank on a single edge. A port number at or above NUM_PORTS captures all zeros.
- R4: A read-entry command loads the capture entry selected by command bits 4:0 into the readout value. Address 0x1E returns its bits 31:16 and address 0x1F returns its bits 15:0.
- R5: Entry 0 is bits 31:0 of the byte counter and entry 1 is bits 63:32 of the byte counter. Entries 2 to NUM_EVT+1 are the event counters in order, zero-extended to 32 bits. Any higher index reads zero.
- R6: An event pulse adds one to its counter. A length strobe adds the port's length input to that port's byte counter.
- R7: Every live counter saturates at all-ones and never wraps.
- R8: An increment that arrives on the same edge as the snapshot copy is absent from the capture but kept in the live counter. A snapshot never clears the live counters.
- R9: The following writes leave busy, the command register and the readout value unchanged: a command write while busy is set, a command write with any other opcode, and writes to 0x1E or 0x1F.
- R10: Read data appears on the cycle after the read request. Addresses other than 0x1D to 0x1F read zero. Read data holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| evt_i | input | NUM_PORTS*NUM_EVT | Event pulses, bit p*NUM_EVT+e for port p, counter e |
| len_vld_i | input | NUM_PORTS | Per-port length strobe |
| len_i | input | NUM_PORTS*LEN_W | Per-port length value, port p at bits p*LEN_W |

## Verification
A command is accepted on the edge that samples its write. Busy is set after that edge, and the copy or entry load takes place on the next edge. A status read issued in the cycle right after the command therefore returns busy set, and the following read returns it clear. High and low reads are issued only after that status read, so they always see the newly loaded entry. Each read request pushes its expected word into a queue. The monitor pops and compares that word one time unit after the edge that registers the read data. To check the same-edge increment case, an event pulse is placed in the cycle of the busy status read, which is the cycle in which the copy happens.

// File: rtl/stat_snap_pkg.sv
package stat_snap_pkg;
  localparam logic [4:0] ADDR_CMD = 5'h1D;
  localparam logic [4:0] ADDR_HI  = 5'h1E;
  localparam logic [4:0] ADDR_LO  = 5'h1F;

  typedef enum logic [3:0] {
    OP_READ = 4'hC,
    OP_SNAP = 4'hD
  } op_e;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  localparam int PAD = W + 1 - INC_W;

  logic [W-1:0] cnt_q;
  logic [W:0]   sum;

  assign sum = {1'b0, cnt_q} + {{PAD{1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (inc_en_i) cnt_q <= sum[W] ? '1 : sum[W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/port_counters.sv
module port_counters #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_EVT   = 12,
  parameter int CNT_W     = 32,
  parameter int WIDE_W    = 64,
  parameter int LEN_W     = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_PORTS*NUM_EVT-1:0]        evt_i,
  input  logic [NUM_PORTS-1:0]                len_vld_i,
  input  logic [NUM_PORTS*LEN_W-1:0]          len_i,
  output logic [NUM_PORTS*WIDE_W-1:0]         wide_o,
  output logic [NUM_PORTS*NUM_EVT*CNT_W-1:0]  evt_cnt_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sat_counter #(.W(WIDE_W), .INC_W(LEN_W)) u_wide (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_en_i (len_vld_i[p]),
      .inc_i    (len_i[p*LEN_W +: LEN_W]),
      .cnt_o    (wide_o[p*WIDE_W +: WIDE_W])
    );
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      sat_counter #(.W(CNT_W), .INC_W(1)) u_evt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .inc_en_i (evt_i[p*NUM_EVT+e]),
        .inc_i    (1'b1),
        .cnt_o    (evt_cnt_o[(p*NUM_EVT+e)*CNT_W +: CNT_W])
      );
    end
  end
endmodule

// File: rtl/snap_bank.sv
module snap_bank #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_EVT   = 12,
  parameter int CNT_W     = 32,
  parameter int WIDE_W    = 64,
  parameter int SEL_W     = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               snap_i,
  input  logic [SEL_W-1:0]                   port_i,
  input  logic [NUM_PORTS*WIDE_W-1:0]        live_wide_i,
  input  logic [NUM_PORTS*NUM_EVT*CNT_W-1:0] live_evt_i,
  output logic [WIDE_W-1:0]                  cap_wide_o,
  output logic [NUM_EVT*CNT_W-1:0]           cap_evt_o
);
  localparam int PORT_BITS = NUM_EVT * CNT_W;

  logic [WIDE_W-1:0]    sel_wide;
  logic [PORT_BITS-1:0] sel_evt;
  logic [WIDE_W-1:0]    cap_wide_q;
  logic [PORT_BITS-1:0] cap_evt_q;

  // out-of-range port leaves both selections at zero
  always_comb begin
    sel_wide = '0;
    sel_evt  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_i == SEL_W'(p)) begin
        sel_wide = live_wide_i[p*WIDE_W +: WIDE_W];
        sel_evt  = live_evt_i[p*PORT_BITS +: PORT_BITS];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_wide_q <= '0;
      cap_evt_q  <= '0;
    end else if (snap_i) begin
      cap_wide_q <= sel_wide;
      cap_evt_q  <= sel_evt;
    end
  end

  assign cap_wide_o = cap_wide_q;
  assign cap_evt_o  = cap_evt_q;
endmodule

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import stat_snap_pkg::*;
#(
  parameter int NUM_EVT = 12,
  parameter int CNT_W   = 32,
  parameter int WIDE_W  = 64,
  parameter int SEL_W   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [4:0]               addr_i,
  input  logic [15:0]              wdata_i,
  output logic [15:0]              rdata_o,
  input  logic [WIDE_W-1:0]        cap_wide_i,
  input  logic [NUM_EVT*CNT_W-1:0] cap_evt_i,
  output logic                     snap_o,
  output logic [SEL_W-1:0]         sel_o,
  output logic                     busy_o,
  output logic [31:0]              readout_o
);
  logic        busy_q;
  logic [15:0] cmd_q;
  logic [31:0] readout_q;
  logic [15:0] rdata_q;
  logic        op_ok;
  logic        cmd_acc;
  logic [63:0] wide_ext;
  logic [31:0] entry;
  logic [SEL_W-1:0] sel;

  assign op_ok   = (wdata_i[15:12] == OP_SNAP) || (wdata_i[15:12] == OP_READ);
  assign cmd_acc = req_i && we_i && (addr_i == ADDR_CMD) && !busy_q && op_ok;
  assign sel     = cmd_q[SEL_W-1:0];
  assign wide_ext = 64'(cap_wide_i);

  always_comb begin
    entry = '0;
    if (sel == SEL_W'(0)) entry = wide_ext[31:0];
    if (sel == SEL_W'(1)) entry = wide_ext[63:32];
    for (int e = 0; e < NUM_EVT; e++) begin
      if (sel == SEL_W'(e + 2)) entry = 32'(cap_evt_i[e*CNT_W +: CNT_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cmd_q     <= '0;
      readout_q <= '0;
    end else begin
      busy_q <= cmd_acc;
      if (cmd_acc) cmd_q <= wdata_i;
      if (busy_q && (cmd_q[15:12] == OP_READ)) readout_q <= entry;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) begin
      case (addr_i)
        ADDR_CMD: rdata_q <= {busy_q, cmd_q[14:0]};
        ADDR_HI:  rdata_q <= readout_q[31:16];
        ADDR_LO:  rdata_q <= readout_q[15:0];
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign snap_o    = busy_q && (cmd_q[15:12] == OP_SNAP);
  assign sel_o     = sel;
  assign busy_o    = busy_q;
  assign readout_o = readout_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/stat_snap_unit.sv
module stat_snap_unit #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_EVT   = 12,
  parameter int CNT_W     = 32,
  parameter int WIDE_W    = 64,
  parameter int LEN_W     = 16,
  parameter int SEL_W     = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [4:0]                   addr_i,
  input  logic [15:0]                  wdata_i,
  output logic [15:0]                  rdata_o,
  input  logic [NUM_PORTS*NUM_EVT-1:0] evt_i,
  input  logic [NUM_PORTS-1:0]         len_vld_i,
  input  logic [NUM_PORTS*LEN_W-1:0]   len_i
);
  logic [NUM_PORTS*WIDE_W-1:0]        live_wide;
  logic [NUM_PORTS*NUM_EVT*CNT_W-1:0] live_evt;
  logic [WIDE_W-1:0]                  cap_wide;
  logic [NUM_EVT*CNT_W-1:0]           cap_evt;
  logic                               snap;
  logic [SEL_W-1:0]                   sel;
  logic                               busy;
  logic [31:0]                        readout;

  port_counters #(
    .NUM_PORTS(NUM_PORTS), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W),
    .WIDE_W(WIDE_W), .LEN_W(LEN_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .len_vld_i (len_vld_i),
    .len_i     (len_i),
    .wide_o    (live_wide),
    .evt_cnt_o (live_evt)
  );

  snap_bank #(
    .NUM_PORTS(NUM_PORTS), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W),
    .WIDE_W(WIDE_W), .SEL_W(SEL_W)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .snap_i      (snap),
    .port_i      (sel),
    .live_wide_i (live_wide),
    .live_evt_i  (live_evt),
    .cap_wide_o  (cap_wide),
    .cap_evt_o   (cap_evt)
  );

  cmd_ctrl #(
    .NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .WIDE_W(WIDE_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cap_wide_i (cap_wide),
    .cap_evt_i  (cap_evt),
    .snap_o     (snap),
    .sel_o      (sel),
    .busy_o     (busy),
    .readout_o  (readout)
  );
endmodule

// File: rtl/stat_snap_chk.sv
module stat_snap_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [4:0]       addr_i,
  input logic [15:0]      wdata_i,
  input logic [15:0]      rdata_i,
  input logic             busy_i,
  input logic [31:0]      readout_i,
  input logic [CNT_W-1:0] cnt_i
);
  logic cmd_wr;
  logic good_op;
  assign cmd_wr  = req_i && we_i && (addr_i == 5'h1D);
  assign good_op = (wdata_i[15:12] == 4'hC) || (wdata_i[15:12] == 4'hD);

  a_r2_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !busy_i);

  a_r2_busy_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && good_op) |=> busy_i);

  a_r9_bad_op_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && !good_op) |=> !busy_i);

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_i >= $past(cnt_i)));

  a_r4_readout_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(readout_i));

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_i));
endmodule

bind stat_snap_unit stat_snap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_i   (rdata_o),
  .busy_i    (busy),
  .readout_i (readout),
  .cnt_i     (live_evt[CNT_W-1:0])
);

// File: tb/stat_snap_unit_test.sv
`timescale 1ns/1ps
module stat_snap_unit_test;
  localparam int NP = 3;
  localparam int NE = 4;
  localparam int CW = 6;
  localparam int WW = 36;
  localparam int LW = 32;
  localparam logic [4:0] A_CMD = 5'h1D;
  localparam logic [4:0] A_HI  = 5'h1E;
  localparam logic [4:0] A_LO  = 5'h1F;
  localparam longint EVT_MAX  = (64'd1 << CW) - 1;
  localparam longint WIDE_MAX = (64'd1 << WW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [NP*NE-1:0] evt = '0;
  logic [NP-1:0] len_vld = '0;
  logic [NP*LW-1:0] len = '0;

  always #2.5 clk = ~clk;

  stat_snap_unit #(
    .NUM_PORTS(NP), .NUM_EVT(NE), .CNT_W(CW), .WIDE_W(WW), .LEN_W(LW), .SEL_W(5)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .len_vld_i(len_vld), .len_i(len)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  longint m_evt[NP][NE];
  longint m_wide[NP];
  longint c_evt[NE];
  longint c_wide;

  // monitor: read data is registered on the sampling edge
  always @(posedge clk) begin
    logic [15:0] e;
    string t;
    if (rst_n && req && !we) begin
      #1;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic defaults();
    req = 0; we = 0; addr = '0; wdata = '0; evt = '0; len_vld = '0; len = '0;
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); defaults();
    req = 1; we = 1; addr = a; wdata = d;
  endtask

  task automatic reg_rd(input logic [4:0] a, input logic [15:0] e, input string t);
    @(negedge clk); defaults();
    exp_q.push_back(e); tag_q.push_back(t);
    req = 1; addr = a;
  endtask

  function automatic longint sat(input longint v, input longint mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic pulse(input int p, input int c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); defaults();
      evt[p*NE+c] = 1'b1;
      m_evt[p][c] = sat(m_evt[p][c] + 1, EVT_MAX);
    end
  endtask

  task automatic add_len(input int p, input logic [31:0] v);
    @(negedge clk); defaults();
    len_vld[p] = 1'b1;
    len[p*LW +: LW] = v;
    m_wide[p] = sat(m_wide[p] + longint'(v), WIDE_MAX);
  endtask

  task automatic model_capture(input int p);
    for (int c = 0; c < NE; c++) c_evt[c] = (p < NP) ? m_evt[p][c] : 0;
    c_wide = (p < NP) ? m_wide[p] : 0;
  endtask

  task automatic snap(input int p);
    reg_wr(A_CMD, 16'hDC00 | 16'(p));
    reg_rd(A_CMD, 16'hDC00 | 16'(p), "R2 busy after snapshot");
    model_capture(p);
    reg_rd(A_CMD, 16'h5C00 | 16'(p), "R2 busy cleared");
  endtask

  function automatic logic [31:0] entry(input int idx);
    if (idx == 0) return c_wide[31:0];
    if (idx == 1) return c_wide[63:32];
    if (idx >= 2 && idx < NE + 2) return 32'(c_evt[idx-2]);
    return 32'h0;
  endfunction

  task automatic rd_stat(input int idx, input string t);
    logic [31:0] v;
    v = entry(idx);
    reg_wr(A_CMD, 16'hCC00 | 16'(idx));
    reg_rd(A_CMD, 16'hCC00 | 16'(idx), {t, " status"});
    reg_rd(A_HI, v[31:16], {t, " high"});
    reg_rd(A_LO, v[15:0], {t, " low"});
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_wide[p] = 0;
      for (int c = 0; c < NE; c++) m_evt[p][c] = 0;
    end
    model_capture(NP);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(A_CMD, 16'h0000, "R1 command reg");
    reg_rd(A_HI, 16'h0000, "R1 high reg");
    reg_rd(A_LO, 16'h0000, "R1 low reg");
    rd_stat(2, "R1 capture clear");

    // R6 counting
    pulse(0, 0, 3);
    pulse(0, 3, 5);
    pulse(1, 1, 2);
    add_len(0, 32'd100);
    add_len(0, 32'd200);
    add_len(1, 32'hFFFF_FFFF);
    add_len(1, 32'hFFFF_FFFF);

    // R3 R4 R5 port 0
    snap(0);
    rd_stat(0, "R5 R6 port0 bytes low");
    rd_stat(1, "R5 port0 bytes high");
    rd_stat(2, "R4 R6 port0 evt0");
    rd_stat(5, "R5 port0 evt3");
    rd_stat(3, "R3 port0 evt1");

    // R5 64-bit pair on port 1
    snap(1);
    rd_stat(0, "R5 port1 low word");
    rd_stat(1, "R5 port1 high word");
    rd_stat(3, "R3 port1 evt1");
    rd_stat(6, "R5 index past end");
    rd_stat(31, "R5 top index");

    // R7 saturation
    pulse(2, 2, 70);
    for (int i = 0; i < 17; i++) add_len(2, 32'hFFFF_FFFF);
    snap(2);
    rd_stat(4, "R7 event saturates");
    rd_stat(0, "R7 bytes low saturates");
    rd_stat(1, "R7 bytes high saturates");

    // R3 port out of range
    snap(5);
    rd_stat(2, "R3 bad port zero");
    rd_stat(0, "R3 bad port bytes");

    // R8 increment on the copy edge
    reg_wr(A_CMD, 16'hDC00);
    @(negedge clk); defaults();
    exp_q.push_back(16'hDC00); tag_q.push_back("R8 busy");
    req = 1; addr = A_CMD;
    evt[0] = 1'b1;
    model_capture(0);
    m_evt[0][0] = sat(m_evt[0][0] + 1, EVT_MAX);
    reg_rd(A_CMD, 16'h5C00, "R8 busy cleared");
    rd_stat(2, "R8 capture holds old value");
    snap(0);
    rd_stat(2, "R8 increment kept");

    // R9 ignored writes (readout now holds 4)
    reg_wr(A_CMD, 16'hDC01);
    reg_wr(A_CMD, 16'hCC02);
    model_capture(1);
    reg_rd(A_CMD, 16'h5C01, "R9 write while busy ignored");
    reg_rd(A_LO, 16'h0004, "R9 readout unchanged after busy write");
    reg_wr(A_CMD, 16'hB003);
    reg_rd(A_CMD, 16'h5C01, "R9 bad opcode ignored");
    reg_rd(A_LO, 16'h0004, "R9 readout unchanged after bad opcode");
    reg_wr(A_HI, 16'h1234);
    reg_wr(A_LO, 16'h5678);
    reg_rd(A_HI, 16'h0000, "R9 high reg write ignored");
    reg_rd(A_LO, 16'h0004, "R9 low reg write ignored");

    // R10 unmapped addresses
    reg_rd(5'h00, 16'h0000, "R10 unmapped zero");
    reg_rd(5'h1C, 16'h0000, "R10 unmapped near cmd");

    @(negedge clk); defaults();
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL pending reads: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule